// File: doc/BRIEF.md
# Common-Case Taint Filter Unit

This unit sits in the in-order taint stage that runs after instruction commit. For each instruction it decides whether the result taint follows from a trivial rule or whether the instruction has to go to the programmable propagation cache. Software programs the decision per opcode through a small table. Each opcode gets a 2-bit code that selects one of three behaviours:

- always look the instruction up in the cache;
- give a zero result for all-zero inputs;
- give a zero result for all-zero inputs, and also pass through the single non-zero source taint.

The instruction brings its opcode, the register index and raw taint of each source, and the active taint width. The unit first qualifies the source taints. A source that names register 0 counts as untainted, and bits above the active width are dropped. The unit then reads the opcode's code and, two clock edges after accepting the instruction, presents its registered result. That result is either a cache lookup request, or a trivial result taint together with a forward enable. Under the forward enable, the taint can go to a dependent instruction in the same cycle. Otherwise a one-cycle hold request is raised for the dependent instruction and every instruction after it.

The table is a 2-bit-wide memory indexed by opcode alone, with no tag. It is written through a dedicated write port and read synchronously, so block RAM can hold it. The table has no reset, so software loads every opcode before use, for example as part of restoring a process context.

Top module: `tf_filter_unit`

## Requirements
- R1: While `rst` is high and on the first edges after it, `out_valid`, `lookup_req`, `fwd_en`, `dep_stall` and `res_taint` are all zero.
- R2: An instruction accepted with `in_valid` high at clock edge k produces `out_valid` high after edge k+2. Results come out one per accepted instruction, in acceptance order, with no gaps for back-to-back input.
- R3: Code 2'b00, and the reserved code 2'b11, always give `lookup_req`=1 with `res_taint`=0, whatever the source taints are.
- R4: Code 2'b01 gives `lookup_req`=0 and `res_taint`=0 when every qualified source taint is zero. Otherwise it gives `lookup_req`=1 and `res_taint`=0.
- R5: Code 2'b10 behaves as 2'b01 for all-zero sources. When exactly one qualified source taint is non-zero, it gives `lookup_req`=0 and sets `res_taint` to that taint. With two or more non-zero sources it gives `lookup_req`=1 and `res_taint`=0.
- R6: A source whose register index is 0 counts as having taint zero, whatever its taint input is.
- R7: Only the low `in_size` bits of each source taint take part (size 1 keeps bit 0, size 2 keeps bits 1:0, and so on). A size of `TAINT_W` or more keeps every bit. `res_taint` never has a bit set at or above the active size.
- R8: With `in_size` = 0 the filter is disabled: `lookup_req`=0 and `res_taint`=0 for every opcode and every set of sources.
- R9: For a valid result, `fwd_en` = NOT `lookup_req` and `dep_stall` = `lookup_req`.
- R10: A code written through the table port at edge k governs instructions accepted at edge k+1 and later. An instruction accepted at the same edge k with the same opcode still sees the old code.
- R11: While `out_valid` is low, `lookup_req`, `fwd_en`, `dep_stall` and `res_taint` are all zero.
- R12: Source i occupies bits [i*REG_W +: REG_W] of `in_src_reg` and bits [i*TAINT_W +: TAINT_W] of `in_src_taint`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | OPC_W | Opcode whose code is written |
| tbl_code | input | 2 | Code written (00 lookup, 01 zero rule, 10 zero+copy rule, 11 reserved) |
| in_valid | input | 1 | Instruction present |
| in_opcode | input | OPC_W | Opcode or opcode class |
| in_size | input | SZ_W | Active taint width in bits; 0 disables the filter |
| in_src_reg | input | NSRC*REG_W | Source register indices, packed per R12 |
| in_src_taint | input | NSRC*TAINT_W | Raw source taints, packed per R12 |
| out_valid | output | 1 | Result present |
| lookup_req | output | 1 | Result must come from the propagation cache |
| res_taint | output | TAINT_W | Trivially computed result taint |
| fwd_en | output | 1 | `res_taint` may be forwarded to a dependent instruction in the same cycle |
| dep_stall | output | 1 | Hold dependent and later instructions one cycle |

## Verification
A table write and an instruction lookup can land on the same edge. When both name the same opcode, the read-before-write ordering decides which code the instruction sees. The bench provokes this by rewriting an opcode from the zero rule to always-lookup in the very cycle an all-zero instruction with that opcode is issued. It expects the old behaviour (no lookup) for that instruction and the new behaviour for an identical instruction issued on the next cycle. It also runs back-to-back streams that mix forwarded and lookup results, so that the forward and hold outputs are judged on consecutive cycles.

// File: rtl/tf_pkg.sv
package tf_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_ALWAYS = 2'b00,
    CODE_ZERO   = 2'b01,
    CODE_COPY   = 2'b10,
    CODE_RSVD   = 2'b11
  } filt_code_e;

endpackage

// File: rtl/tf_code_table.sv
module tf_code_table #(
  parameter int OPC_W  = 8,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [OPC_W-1:0]  waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              re,
  input  logic [OPC_W-1:0]  raddr,
  output logic [CODE_W-1:0] rdata
);
  localparam int DEPTH = 1 << OPC_W;

  logic [CODE_W-1:0] mem [DEPTH];

  // Read-first single clock RAM: a same-edge read returns the old word.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tf_src_qual.sv
module tf_src_qual #(
  parameter int NSRC    = 2,
  parameter int REG_W   = 5,
  parameter int TAINT_W = 4,
  parameter int SZ_W    = 3
) (
  input  logic [SZ_W-1:0]         size,
  input  logic [NSRC*REG_W-1:0]   src_reg,
  input  logic [NSRC*TAINT_W-1:0] src_taint,
  output logic [NSRC*TAINT_W-1:0] eff_taint,
  output logic [NSRC-1:0]         nz,
  output logic                    disabled
);
  logic [TAINT_W-1:0] mask;

  always_comb begin
    for (int b = 0; b < TAINT_W; b++) begin
      mask[b] = (size > SZ_W'(b));
    end
  end

  assign disabled = (size == '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic               is_r0;
    logic [TAINT_W-1:0] t;
    assign is_r0 = (src_reg[i*REG_W +: REG_W] == '0);
    assign t     = is_r0 ? '0 : (src_taint[i*TAINT_W +: TAINT_W] & mask);
    assign eff_taint[i*TAINT_W +: TAINT_W] = t;
    assign nz[i] = |t;
  end
endmodule

// File: rtl/tf_decide.sv
module tf_decide #(
  parameter int NSRC    = 2,
  parameter int TAINT_W = 4
) (
  input  tf_pkg::filt_code_e      code,
  input  logic                    disabled,
  input  logic [NSRC-1:0]         nz,
  input  logic [NSRC*TAINT_W-1:0] eff_taint,
  output logic                    lookup,
  output logic [TAINT_W-1:0]      res
);
  import tf_pkg::*;

  localparam int CNT_W = $clog2(NSRC + 1);

  logic [CNT_W-1:0]   nz_cnt;
  logic [TAINT_W-1:0] merged;
  logic               none_nz;
  logic               one_nz;

  always_comb begin
    nz_cnt = '0;
    merged = '0;
    for (int i = 0; i < NSRC; i++) begin
      nz_cnt = nz_cnt + CNT_W'(nz[i]);
      merged = merged | eff_taint[i*TAINT_W +: TAINT_W];
    end
  end

  assign none_nz = (nz_cnt == '0);
  assign one_nz  = (nz_cnt == CNT_W'(1));

  always_comb begin
    lookup = 1'b0;
    res    = '0;
    if (!disabled) begin
      unique case (code)
        CODE_ZERO: lookup = !none_nz;
        CODE_COPY: begin
          if (one_nz) res = merged;
          else        lookup = !none_nz;
        end
        default:   lookup = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tf_filter_unit.sv
module tf_filter_unit #(
  parameter int OPC_W   = 8,
  parameter int NSRC    = 2,
  parameter int REG_W   = 5,
  parameter int TAINT_W = 4,
  parameter int SZ_W    = $clog2(TAINT_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tbl_we,
  input  logic [OPC_W-1:0]        tbl_addr,
  input  logic [1:0]              tbl_code,
  input  logic                    in_valid,
  input  logic [OPC_W-1:0]        in_opcode,
  input  logic [SZ_W-1:0]         in_size,
  input  logic [NSRC*REG_W-1:0]   in_src_reg,
  input  logic [NSRC*TAINT_W-1:0] in_src_taint,
  output logic                    out_valid,
  output logic                    lookup_req,
  output logic [TAINT_W-1:0]      res_taint,
  output logic                    fwd_en,
  output logic                    dep_stall
);
  import tf_pkg::*;

  // Stage 0: qualify sources and read the code.
  logic [NSRC*TAINT_W-1:0] q_eff;
  logic [NSRC-1:0]         q_nz;
  logic                    q_dis;
  logic [CODE_W-1:0]       s1_code_raw;

  tf_src_qual #(
    .NSRC(NSRC), .REG_W(REG_W), .TAINT_W(TAINT_W), .SZ_W(SZ_W)
  ) u_qual (
    .size(in_size), .src_reg(in_src_reg), .src_taint(in_src_taint),
    .eff_taint(q_eff), .nz(q_nz), .disabled(q_dis)
  );

  tf_code_table #(.OPC_W(OPC_W), .CODE_W(CODE_W)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_code),
    .re(in_valid), .raddr(in_opcode), .rdata(s1_code_raw)
  );

  logic                    s1_valid;
  logic [NSRC*TAINT_W-1:0] s1_eff;
  logic [NSRC-1:0]         s1_nz;
  logic                    s1_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_eff   <= '0;
      s1_nz    <= '0;
      s1_dis   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_eff <= q_eff;
        s1_nz  <= q_nz;
        s1_dis <= q_dis;
      end
    end
  end

  // Stage 1: decide and register the outputs.
  logic               d_lookup;
  logic [TAINT_W-1:0] d_res;

  tf_decide #(.NSRC(NSRC), .TAINT_W(TAINT_W)) u_dec (
    .code(filt_code_e'(s1_code_raw)), .disabled(s1_dis), .nz(s1_nz),
    .eff_taint(s1_eff), .lookup(d_lookup), .res(d_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      lookup_req <= 1'b0;
      res_taint  <= '0;
      fwd_en     <= 1'b0;
      dep_stall  <= 1'b0;
    end else begin
      out_valid  <= s1_valid;
      lookup_req <= s1_valid & d_lookup;
      res_taint  <= s1_valid ? d_res : '0;
      fwd_en     <= s1_valid & ~d_lookup;
      dep_stall  <= s1_valid & d_lookup;
    end
  end
endmodule

// File: rtl/tf_filter_chk.sv
module tf_filter_chk #(
  parameter int OPC_W   = 8,
  parameter int NSRC    = 2,
  parameter int TAINT_W = 4,
  parameter int SZ_W    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [SZ_W-1:0]    in_size,
  input logic               out_valid,
  input logic               lookup_req,
  input logic [TAINT_W-1:0] res_taint,
  input logic               fwd_en,
  input logic               dep_stall
);
  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end
  assign warm = (since_rst == 2'd2);

  function automatic logic [TAINT_W-1:0] size_mask(input logic [SZ_W-1:0] s);
    for (int b = 0; b < TAINT_W; b++) size_mask[b] = (s > SZ_W'(b));
  endfunction

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!lookup_req && !fwd_en && !dep_stall && res_taint == '0));

  // R9
  fwd_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((fwd_en != dep_stall) && (dep_stall == lookup_req)));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    out_valid == $past(in_valid, 2));

  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    ($past(in_valid, 2) && $past(in_size, 2) == '0) |-> (!lookup_req && res_taint == '0));

  // R7
  size_mask_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    out_valid |-> ((res_taint & ~size_mask($past(in_size, 2))) == '0));

  // R3
  lookup_zero_res_chk: assert property (@(posedge clk) disable iff (rst)
    lookup_req |-> (res_taint == '0));
endmodule

bind tf_filter_unit tf_filter_chk #(
  .OPC_W(OPC_W), .NSRC(NSRC), .TAINT_W(TAINT_W), .SZ_W(SZ_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
  .out_valid(out_valid), .lookup_req(lookup_req), .res_taint(res_taint),
  .fwd_en(fwd_en), .dep_stall(dep_stall)
);

// File: tb/tf_filter_unit_tb_top.sv
module tf_filter_unit_tb_top;
  localparam int OPC_W = 8, NSRC = 2, REG_W = 5, TAINT_W = 4, SZ_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [OPC_W-1:0] tbl_addr = '0;
  logic [1:0] tbl_code = '0;
  logic in_valid = 1'b0;
  logic [OPC_W-1:0] in_opcode = '0;
  logic [SZ_W-1:0] in_size = '0;
  logic [NSRC*REG_W-1:0] in_src_reg = '0;
  logic [NSRC*TAINT_W-1:0] in_src_taint = '0;
  logic out_valid, lookup_req, fwd_en, dep_stall;
  logic [TAINT_W-1:0] res_taint;

  always #5 clk = ~clk;

  tf_filter_unit #(.OPC_W(OPC_W), .NSRC(NSRC), .REG_W(REG_W), .TAINT_W(TAINT_W)) dut_i (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_code(tbl_code),
    .in_valid(in_valid), .in_opcode(in_opcode), .in_size(in_size),
    .in_src_reg(in_src_reg), .in_src_taint(in_src_taint),
    .out_valid(out_valid), .lookup_req(lookup_req), .res_taint(res_taint),
    .fwd_en(fwd_en), .dep_stall(dep_stall)
  );

  typedef struct {
    logic               lk;
    logic [TAINT_W-1:0] res;
    string              tag;
  } exp_t;

  exp_t exp_q[$];
  logic [1:0] model_tbl [1 << OPC_W];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [TAINT_W-1:0] qual(input logic [SZ_W-1:0] sz,
                                              input logic [REG_W-1:0] r,
                                              input logic [TAINT_W-1:0] t);
    logic [TAINT_W-1:0] m;
    for (int b = 0; b < TAINT_W; b++) m[b] = (int'(sz) > b);
    return (r == 0) ? '0 : (t & m);
  endfunction

  function automatic exp_t model(input logic [1:0] code, input logic [SZ_W-1:0] sz,
                                 input logic [REG_W-1:0] r0, input logic [TAINT_W-1:0] t0,
                                 input logic [REG_W-1:0] r1, input logic [TAINT_W-1:0] t1);
    exp_t e;
    logic [TAINT_W-1:0] a, b;
    int n;
    a = qual(sz, r0, t0);
    b = qual(sz, r1, t1);
    n = int'(a != 0) + int'(b != 0);
    e.lk = 1'b0;
    e.res = '0;
    e.tag = "";
    if (sz != 0) begin
      if (code == 2'b01)      e.lk = (n != 0);
      else if (code == 2'b10) begin
        if (n == 1) e.res = a | b;
        else        e.lk = (n != 0);
      end else                e.lk = 1'b1;
    end
    return e;
  endfunction

  // Driver: one call per clock; optional table write and optional instruction.
  task automatic step(input bit do_wr, input logic [OPC_W-1:0] wa, input logic [1:0] wc,
                      input bit do_iss, input logic [OPC_W-1:0] op, input logic [SZ_W-1:0] sz,
                      input logic [REG_W-1:0] r0, input logic [TAINT_W-1:0] t0,
                      input logic [REG_W-1:0] r1, input logic [TAINT_W-1:0] t1,
                      input string tag);
    exp_t e;
    @(negedge clk);
    tbl_we = do_wr;
    tbl_addr = wa;
    tbl_code = wc;
    in_valid = do_iss;
    in_opcode = op;
    in_size = sz;
    in_src_reg = {r1, r0};
    in_src_taint = {t1, t0};
    if (do_iss) begin
      e = model(model_tbl[op], sz, r0, t0, r1, t1); // old code on same-edge write (R10)
      e.tag = tag;
      exp_q.push_back(e);
    end
    if (do_wr) model_tbl[wa] = wc;
  endtask

  task automatic iss(input logic [OPC_W-1:0] op, input logic [SZ_W-1:0] sz,
                     input logic [REG_W-1:0] r0, input logic [TAINT_W-1:0] t0,
                     input logic [REG_W-1:0] r1, input logic [TAINT_W-1:0] t1,
                     input string tag);
    step(1'b0, '0, '0, 1'b1, op, sz, r0, t0, r1, t1, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, '0, '0, '0, '0, '0, '0, "");
  endtask

  // Monitor: pops one expectation per valid result.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected result lk=%0b res=%h, expected none", lookup_req, res_taint);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (lookup_req !== e.lk || res_taint !== e.res ||
              fwd_en !== !e.lk || dep_stall !== e.lk) begin
            errors++;
            $display("FAIL %s: got lk=%0b res=%h fwd=%0b stall=%0b, expected lk=%0b res=%h fwd=%0b stall=%0b",
                     e.tag, lookup_req, res_taint, fwd_en, dep_stall, e.lk, e.res, !e.lk, e.lk);
          end
        end
      end
    end
  end

  task automatic check_quiet(input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || lookup_req !== 1'b0 || fwd_en !== 1'b0 ||
        dep_stall !== 1'b0 || res_taint !== '0) begin
      errors++;
      $display("FAIL %s: got v=%0b lk=%0b fwd=%0b stall=%0b res=%h, expected all zero",
               tag, out_valid, lookup_req, fwd_en, dep_stall, res_taint);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    check_quiet("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    check_quiet("R1 after reset");

    // Load every opcode: code = opcode mod 4.
    for (int a = 0; a < (1 << OPC_W); a++) step(1'b1, OPC_W'(a), 2'(a % 4), 1'b0, '0, '0, '0, '0, '0, '0, "");

    // R3 always-lookup and reserved code
    iss(8'd4, 3'd4, 5'd1, 4'h0, 5'd2, 4'h0, "R3 code00 zero srcs");
    iss(8'd7, 3'd4, 5'd1, 4'h0, 5'd2, 4'h0, "R3 code11 zero srcs");
    iss(8'd8, 3'd4, 5'd1, 4'h5, 5'd2, 4'h0, "R3 code00 one src");
    // R4 zero rule
    iss(8'd1, 3'd4, 5'd1, 4'h0, 5'd2, 4'h0, "R4 code01 all zero");
    iss(8'd1, 3'd4, 5'd1, 4'h0, 5'd2, 4'h6, "R4 code01 one nonzero");
    // R5 copy rule, R12 packing of either source
    iss(8'd2, 3'd4, 5'd3, 4'h0, 5'd4, 4'h5, "R5 R12 copy src1");
    iss(8'd6, 3'd4, 5'd3, 4'h9, 5'd4, 4'h0, "R5 R12 copy src0");
    iss(8'd2, 3'd4, 5'd3, 4'h9, 5'd4, 4'h5, "R5 two nonzero");
    iss(8'd2, 3'd4, 5'd3, 4'h0, 5'd4, 4'h0, "R5 all zero");
    idle(1);
    // R6 register 0 is untainted
    iss(8'd2, 3'd4, 5'd0, 4'h9, 5'd4, 4'h3, "R6 r0 ignored copy");
    iss(8'd1, 3'd4, 5'd0, 4'hF, 5'd0, 4'hF, "R6 both r0");
    // R7 width masking
    iss(8'd2, 3'd2, 5'd1, 4'hC, 5'd2, 4'h0, "R7 size2 high bits dropped");
    iss(8'd2, 3'd2, 5'd1, 4'h7, 5'd2, 4'h0, "R7 size2 low bits kept");
    iss(8'd2, 3'd7, 5'd1, 4'hE, 5'd2, 4'h0, "R7 size7 full width");
    iss(8'd1, 3'd1, 5'd1, 4'h2, 5'd2, 4'h0, "R7 size1 bit1 dropped");
    // R8 disabled filter
    iss(8'd4, 3'd0, 5'd1, 4'hF, 5'd2, 4'hA, "R8 size0 code00");
    iss(8'd2, 3'd0, 5'd1, 4'h3, 5'd2, 4'h0, "R8 size0 code10");
    idle(3);
    check_quiet("R11 idle");
    // R10 same-edge write sees old code, next instruction sees new code
    step(1'b1, 8'd1, 2'b00, 1'b1, 8'd1, 3'd4, 5'd1, 4'h0, 5'd2, 4'h0, "R10 same-edge old code");
    iss(8'd1, 3'd4, 5'd1, 4'h0, 5'd2, 4'h0, "R10 next uses new code");
    step(1'b1, 8'd3, 2'b10, 1'b0, '0, '0, '0, '0, '0, '0, "");
    iss(8'd3, 3'd4, 5'd1, 4'h4, 5'd2, 4'h0, "R10 reserved rewritten to copy");
    // R2 R9 back-to-back mixed stream
    for (int k = 0; k < 12; k++)
      iss(8'(k), 3'd4, 5'd1, 4'(k), 5'd2, 4'(k % 3), "R2 R9 stream");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: got %0d missing results, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule